// File: doc/BRIEF.md
# Bitmap CHR Address Substitution Unit

This block sits between the picture processor's 14-bit address bus and an 8 KiB unbanked character RAM mapped at $0000-$1FFF. It turns the tile-based pattern memory into a one-bit-per-pixel, all-points-addressable frame buffer. It watches every picture-processor read. When a read lands on a true tile-index fetch, meaning a nametable entry and not an attribute byte, it remembers two bits of that fetch address. While the bitmap mode is on, it then steers the following pattern fetches with those remembered bits.

The mode flag is loaded by a write strobe from the mapper's register decoder and is stored here. The character address is formed combinationally from the current bus address, the stored mode and the stored bits. Captures and mode loads take effect at the next rising clock edge.

Top module: `bitmap_chr_remap`

## Requirements
- R1: After reset the mode flag is off and both remembered bits are 0, so `chr_addr` equals `ppu_addr[12:0]`.
- R2: While the mode flag is 0, `chr_addr` equals `ppu_addr[12:0]` for every address.
- R3: While the mode flag is 1, `chr_addr[3]` equals address bit 0 of the most recent captured nametable read.
- R4: While the mode flag is 1, `chr_addr[12]` equals address bit 9 of the most recent captured nametable read.
- R5: A read is captured only when `ppu_addr` is in $2000-$2FFF and its offset within the 1 KiB table (`ppu_addr[9:0]`) is below $3C0. Reads at offsets $3C0-$3FF (attribute bytes) and reads at $3000 and above leave both remembered bits unchanged.
- R6: With `ppu_rd` low, no address changes the remembered bits.
- R7: Pattern reads ($0000-$1FFF) leave the remembered bits unchanged, so one capture steers every pattern fetch that follows it.
- R8: `chr_sel` is 1 exactly when `ppu_rd` is 1 and `ppu_addr[13]` is 0.
- R9: `mode_we` high at a rising edge loads `mode_val` into the mode flag. The new value steers `chr_addr` from the next cycle on, and not in the cycle of the write.
- R10: A captured read updates the remembered bits at the rising edge that ends that read's cycle. Its effect is visible on the next cycle's address.
- R11: In both modes, `chr_addr` bits other than 3 and 12 equal the same bits of `ppu_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ppu_addr | input | 14 | Picture-processor address bus |
| ppu_rd | input | 1 | Read strobe, one cycle per access |
| mode_we | input | 1 | Load strobe for the bitmap mode flag |
| mode_val | input | 1 | Value loaded into the mode flag |
| chr_addr | output | 13 | Character RAM address |
| chr_sel | output | 1 | Character RAM select |

## Verification
Two events can coincide: a load of the mode flag and a nametable capture in the same cycle, or a mode load in the same cycle as a pattern fetch. The bench drives these coincidences on purpose. It checks that the pattern fetch in the write cycle still uses the old mode, and that the next pattern fetch uses both the new mode and the freshly captured bits. A behavioural model advanced once per clock judges every cycle, including a long stretch of pseudo-random addresses, strobes and mode writes.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

    // Registered state of the substitution unit.
    typedef struct packed {
        logic mode;    // bitmap mode active
        logic lat_lo;  // remembered low source bit
        logic lat_hi;  // remembered high source bit
    } bmc_state_t;

    localparam bmc_state_t BMC_RESET = '{mode: 1'b0, lat_lo: 1'b0, lat_hi: 1'b0};

endpackage

// File: rtl/bmc_nt_decode.sv
module bmc_nt_decode #(
    parameter int ADDR_W     = 14,
    parameter int TBL_W      = 10,
    parameter int ATTR_START = 'h3C0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    output logic              capture
);
    localparam logic [1:0] NT_REGION = 2'b10;

    logic in_region;
    logic below_attr;

    always_comb begin
        in_region  = (addr[ADDR_W-1 -: 2] == NT_REGION);
        below_attr = (int'(addr[TBL_W-1:0]) < ATTR_START);
        capture    = rd & in_region & below_attr;
    end
endmodule

// File: rtl/bmc_state.sv
module bmc_state
    import bmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_we,
    input  logic mode_val,
    input  logic capture,
    input  logic src_lo,
    input  logic src_hi,
    output logic mode_q,
    output logic lat_lo_q,
    output logic lat_hi_q
);
    bmc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mode_we) begin
            st_d.mode = mode_val;
        end
        if (capture) begin
            st_d.lat_lo = src_lo;
            st_d.lat_hi = src_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= BMC_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q   = st_q.mode;
    assign lat_lo_q = st_q.lat_lo;
    assign lat_hi_q = st_q.lat_hi;
endmodule

// File: rtl/bmc_addr_mux.sv
module bmc_addr_mux #(
    parameter int CHR_W  = 13,
    parameter int SUB_LO = 3,
    parameter int SUB_HI = 12
) (
    input  logic [CHR_W-1:0] addr_in,
    input  logic             mode,
    input  logic             lat_lo,
    input  logic             lat_hi,
    output logic [CHR_W-1:0] addr_out
);
    for (genvar i = 0; i < CHR_W; i++) begin : g_bit
        if (i == SUB_LO) begin : g_lo
            assign addr_out[i] = mode ? lat_lo : addr_in[i];
        end else if (i == SUB_HI) begin : g_hi
            assign addr_out[i] = mode ? lat_hi : addr_in[i];
        end else begin : g_pass
            assign addr_out[i] = addr_in[i];
        end
    end
endmodule

// File: rtl/bitmap_chr_remap.sv
module bitmap_chr_remap #(
    parameter int ADDR_W     = 14,
    parameter int CHR_W      = 13,
    parameter int TBL_W      = 10,
    parameter int ATTR_START = 'h3C0,
    parameter int SRC_LO     = 0,
    parameter int SRC_HI     = 9,
    parameter int SUB_LO     = 3,
    parameter int SUB_HI     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ppu_addr,
    input  logic              ppu_rd,
    input  logic              mode_we,
    input  logic              mode_val,
    output logic [CHR_W-1:0]  chr_addr,
    output logic              chr_sel
);
    localparam int HI_W = ADDR_W - CHR_W;

    logic capture;
    logic mode_q, lat_lo_q, lat_hi_q;

    bmc_nt_decode #(
        .ADDR_W(ADDR_W), .TBL_W(TBL_W), .ATTR_START(ATTR_START)
    ) u_dec (
        .addr(ppu_addr), .rd(ppu_rd), .capture(capture)
    );

    bmc_state u_state (
        .clk(clk), .rst_n(rst_n),
        .mode_we(mode_we), .mode_val(mode_val),
        .capture(capture),
        .src_lo(ppu_addr[SRC_LO]), .src_hi(ppu_addr[SRC_HI]),
        .mode_q(mode_q), .lat_lo_q(lat_lo_q), .lat_hi_q(lat_hi_q)
    );

    bmc_addr_mux #(
        .CHR_W(CHR_W), .SUB_LO(SUB_LO), .SUB_HI(SUB_HI)
    ) u_mux (
        .addr_in(ppu_addr[CHR_W-1:0]), .mode(mode_q),
        .lat_lo(lat_lo_q), .lat_hi(lat_hi_q), .addr_out(chr_addr)
    );

    assign chr_sel = ppu_rd & (ppu_addr[ADDR_W-1 -: HI_W] == '0);
endmodule

// File: rtl/bmc_chk.sv
module bmc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [13:0] ppu_addr,
    input logic        ppu_rd,
    input logic        mode_we,
    input logic        mode_val,
    input logic [12:0] chr_addr,
    input logic        chr_sel,
    input logic        mode_q,
    input logic        lat_lo_q,
    input logic        lat_hi_q
);
    logic nt_hit, attr_hit;
    assign nt_hit   = ppu_rd && ppu_addr[13:12] == 2'b10 && ppu_addr[9:6] != 4'hF;
    assign attr_hit = ppu_rd && ppu_addr[13:12] == 2'b10 && ppu_addr[9:6] == 4'hF;

    // R8
    sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chr_sel |-> (ppu_rd && !ppu_addr[13]));
    // R2
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> chr_addr == ppu_addr[12:0]);
    // R11
    other_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chr_addr[11:4] == ppu_addr[11:4] && chr_addr[2:0] == ppu_addr[2:0]);
    // R3
    lo_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> chr_addr[3] == lat_lo_q);
    // R4
    hi_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> chr_addr[12] == lat_hi_q);
    // R10
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nt_hit |=> (lat_lo_q == $past(ppu_addr[0]) && lat_hi_q == $past(ppu_addr[9])));
    // R5
    attr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        attr_hit |=> ($stable(lat_lo_q) && $stable(lat_hi_q)));
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ppu_rd |=> ($stable(lat_lo_q) && $stable(lat_hi_q)));
    // R9
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> mode_q == $past(mode_val));
endmodule

bind bitmap_chr_remap bmc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ppu_addr(ppu_addr), .ppu_rd(ppu_rd),
    .mode_we(mode_we), .mode_val(mode_val), .chr_addr(chr_addr),
    .chr_sel(chr_sel), .mode_q(mode_q), .lat_lo_q(lat_lo_q), .lat_hi_q(lat_hi_q)
);

// File: tb/bitmap_chr_remap_tb.sv
module bitmap_chr_remap_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] ppu_addr = '0;
    logic        ppu_rd = 1'b0;
    logic        mode_we = 1'b0;
    logic        mode_val = 1'b0;
    logic [12:0] chr_addr;
    logic        chr_sel;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // behavioural reference state
    int m_mode = 0;
    int m_b0 = 0;
    int m_b9 = 0;

    always #10 clk = ~clk;

    bitmap_chr_remap u_dut (
        .clk(clk), .rst_n(rst_n), .ppu_addr(ppu_addr), .ppu_rd(ppu_rd),
        .mode_we(mode_we), .mode_val(mode_val),
        .chr_addr(chr_addr), .chr_sel(chr_sel)
    );

    function automatic int exp_addr(int a);
        int r = a & 'h1FFF;
        if (m_mode != 0) begin
            r = (r & ~('h1008)) | (m_b9 << 12) | (m_b0 << 3);
        end
        return r;
    endfunction

    task automatic step(input int a, input bit rd, input bit we, input bit val, input string tag);
        int ea, es;
        @(negedge clk);
        ppu_addr = a[13:0]; ppu_rd = rd; mode_we = we; mode_val = val;
        #2;
        ea = exp_addr(a);
        es = (rd && a < 'h2000) ? 1 : 0;
        vectors++;
        if (int'(chr_addr) != ea || int'(chr_sel) != es) begin
            miscompares++;
            $display("FAIL %s addr=%h: chr_addr=%h sel=%0d expected chr_addr=%h sel=%0d",
                     tag, a, chr_addr, chr_sel, ea, es);
        end
        @(posedge clk);
        if (we) m_mode = val;
        if (rd && a >= 'h2000 && a < 'h3000 && (a & 'h3FF) < 'h3C0) begin
            m_b0 = a & 1;
            m_b9 = (a >> 9) & 1;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        step('h1FFF, 1, 0, 0, "R1");
        step('h0000, 1, 0, 0, "R1");
        // R2 passthrough with captures happening underneath
        step('h2201, 1, 0, 0, "R2");
        step('h1008, 1, 0, 0, "R2");
        step('h0AB7, 1, 0, 0, "R2");
        // R9 mode load, write cycle still old mode
        step('h1FF7, 1, 1, 1, "R9");
        step('h0000, 1, 0, 0, "R9");
        // R3/R4 with latch from $2201 (b0=1, b9=1)
        step('h0000, 1, 0, 0, "R3");
        step('h1FFF, 1, 0, 0, "R4");
        // R10 new capture then visible next cycle
        step('h2000, 1, 0, 0, "R10");
        step('h1FFF, 1, 0, 0, "R10");
        step('h2C01, 1, 0, 0, "R10");
        step('h0000, 1, 0, 0, "R10");
        // R5 attribute bytes and upper region ignored
        step('h23C0, 1, 0, 0, "R5");
        step('h0000, 1, 0, 0, "R5");
        step('h2FFF, 1, 0, 0, "R5");
        step('h0000, 1, 0, 0, "R5");
        step('h3201, 1, 0, 0, "R5");
        step('h0000, 1, 0, 0, "R5");
        step('h23BE, 1, 0, 0, "R5");
        step('h0FFF, 1, 0, 0, "R5");
        // R6 no strobe, no capture
        step('h2201, 0, 0, 0, "R6");
        step('h0000, 1, 0, 0, "R6");
        // R7 pattern fetches keep the latch
        step('h1FFF, 1, 0, 0, "R7");
        step('h0008, 1, 0, 0, "R7");
        step('h1000, 1, 0, 0, "R7");
        // R8 select range
        step('h2000, 0, 0, 0, "R8");
        step('h3FFF, 1, 0, 0, "R8");
        step('h1234, 0, 0, 0, "R8");
        // R11 other bits in mode 1
        step('h0AA5, 1, 0, 0, "R11");
        // collision: mode off with capture same cycle, then on with capture
        step('h2201, 1, 1, 0, "R9");
        step('h1FF7, 1, 0, 0, "R2");
        step('h2000, 1, 1, 1, "R9");
        step('h1FFF, 1, 0, 0, "R10");
        // pseudo-random stretch
        for (int i = 0; i < 3000; i++) begin
            int a = (i * 40503 + 12345) & 'h3FFF;
            bit rd = ((i * 7) % 5) != 0;
            bit we = (i % 37) == 0;
            bit val = ((i / 37) % 2) == 0;
            if ((i % 3) == 0) a = 'h2000 | (a & 'h0FFF);
            step(a, rd, we, val, "R11");
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule